// File: doc/BRIEF.md
# Circular Stack Address Mapper

This block keeps a word-aligned 16-bit stack pointer and turns it into a physical word address inside a small on-chip stack window. A push strobe moves the pointer down by one word and a pop strobe moves it up by one word. For every push or pop the block presents one registered physical address, which the surrounding logic uses to access the stack RAM.

The physical address is a splice of two values. The low bits come from the pointer, and the number of low bits depends on a stack-size code. The remaining upper bits come from a fixed upper stack limit, 0xFBFE. As a result, accesses wrap around inside the window while the pointer itself keeps moving in a straight line. A wide pass-through code turns the wrap off.

Two programmable bounds are compared against the pointer after each move. When the pointer goes past a bound, a sticky overflow or underflow flag is raised. The pointer, both bounds and the size code can each be loaded synchronously from a shared data bus.

Top module: `stk_circ_mapper`

## Requirements
- R1: When `rst` is high, the block resets to the following state: pointer 0xFC00, overflow bound 0xFA00, underflow bound 0xFC00, size code 000, both flags clear and `addr_vld_o` low.
- R2: A push moves the pointer down by 2. The physical address is formed from the decremented pointer, and `addr_vld_o` is high in the cycle after the push.
- R3: A pop forms the physical address from the current pointer and then moves the pointer up by 2. `addr_vld_o` is high in the cycle after the pop.
- R4: Size code 000 selects 256 words. Address bits 8..0 come from the pointer and bits 15..9 come from 0xFBFE. For example, pointer 0xF802 maps to 0xFA02 and pointer 0xF800 maps to 0xFA00.
- R5: The other size codes set how many low pointer bits are kept: 001 keeps 8 bits (128 words), 010 keeps 7 bits (64 words), 011 keeps 6 bits (32 words) and 100 keeps 10 bits (512 words). For example, pointer 0xF7FE with code 010 maps to 0xFBFE.
- R6: Code 111 passes the whole pointer through as the address. Codes 101 and 110 behave like code 000.
- R7: A push below the bottom of the window wraps the address to the top of the window (pointer 0xF7FE maps to 0xFBFE with code 000). A pop at the top of the window is followed by an address at the bottom.
- R8: Bit 0 of the pointer and of the address is always 0. A loaded pointer has its bit 0 cleared.
- R9: The overflow flag is set when a push leaves the pointer below the overflow bound (unsigned compare). The flag stays set until `clr_ovf_i` is asserted. If a set and a clear happen in the same cycle, the set wins.
- R10: The underflow flag is set when a pop leaves the pointer above the underflow bound. The flag stays set until `clr_unf_i` is asserted. If a set and a clear happen in the same cycle, the set wins.
- R11: A push and a pop in the same cycle are ignored. The pointer does not change and `addr_vld_o` stays low.
- R12: The strobes `ld_sp_i`, `ld_ovf_i` and `ld_unf_i` load `ld_data_i` into the pointer, the overflow bound and the underflow bound. `ld_size_i` loads `ld_data_i[2:0]` into the size code. A pointer load overrides any push or pop in the same cycle, and that push or pop produces no valid address. A push or pop uses the bounds and size code that were held before the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| push_i | input | 1 | Push one word |
| pop_i | input | 1 | Pop one word |
| ld_sp_i | input | 1 | Load the pointer from `ld_data_i` |
| ld_ovf_i | input | 1 | Load the overflow bound |
| ld_unf_i | input | 1 | Load the underflow bound |
| ld_size_i | input | 1 | Load the size code from `ld_data_i[2:0]` |
| ld_data_i | input | 16 | Shared load data |
| clr_ovf_i | input | 1 | Clear the overflow flag |
| clr_unf_i | input | 1 | Clear the underflow flag |
| sp_o | output | 16 | Current pointer |
| phys_addr_o | output | 16 | Registered physical address |
| addr_vld_o | output | 1 | Address valid for the push or pop of the previous cycle |
| ovf_flag_o | output | 1 | Sticky overflow flag |
| unf_flag_o | output | 1 | Sticky underflow flag |

## Verification
The bench builds the block with its default parameters: a 16-bit pointer, an upper limit of 0xFBFE and a 256-word base size. With these values the literal mapping examples can be checked exactly. Every one of the eight size codes can be loaded, so the bench covers the keep-widths of 6 to 10 bits, the reserved codes and the pass-through code. Sequences of pushes and pops run long enough to cross the window edges in both directions, and the reset bounds sit close enough to the reset pointer that both flags can be reached in a few operations.

// File: rtl/stkmap_pkg.sv
package stkmap_pkg;

  localparam int unsigned SZ_CODE_W = 3;
  localparam int unsigned NUM_CODES = 1 << SZ_CODE_W;

  typedef logic [SZ_CODE_W-1:0] sz_code_t;

  localparam sz_code_t SZ_BASE = 3'd0;  // base window (256 words by default)
  localparam sz_code_t SZ_HALF = 3'd1;
  localparam sz_code_t SZ_QTR  = 3'd2;
  localparam sz_code_t SZ_8TH  = 3'd3;
  localparam sz_code_t SZ_DBL  = 3'd4;
  localparam sz_code_t SZ_FLAT = 3'd7;  // no wrap, full pointer

  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_PUSH = 2'd1,
    OP_POP  = 2'd2
  } stk_op_e;

  // Number of byte-address bits taken from the pointer for a size code.
  function automatic int unsigned keep_bits(input sz_code_t c,
                                            input int unsigned base_log2,
                                            input int unsigned aw);
    int unsigned n;
    case (c)
      SZ_HALF: n = base_log2;
      SZ_QTR:  n = base_log2 - 1;
      SZ_8TH:  n = base_log2 - 2;
      SZ_DBL:  n = base_log2 + 2;
      SZ_FLAT: n = aw;
      default: n = base_log2 + 1;
    endcase
    if (n > aw) n = aw;
    return n;
  endfunction

endpackage

// File: rtl/stk_op_decode.sv
module stk_op_decode
  import stkmap_pkg::*;
(
  input  logic    push_i,
  input  logic    pop_i,
  input  logic    hold_i,
  output stk_op_e op_o
);

  always_comb begin
    op_o = OP_IDLE;
    if (!hold_i) begin
      if (push_i && !pop_i)      op_o = OP_PUSH;
      else if (pop_i && !push_i) op_o = OP_POP;
    end
  end

endmodule

// File: rtl/stk_ptr_regs.sv
module stk_ptr_regs
  import stkmap_pkg::*;
#(
  parameter int unsigned   AW      = 16,
  parameter logic [AW-1:0] RST_SP  = 16'hFC00,
  parameter logic [AW-1:0] RST_OVF = 16'hFA00,
  parameter logic [AW-1:0] RST_UNF = 16'hFC00
) (
  input  logic          clk,
  input  logic          rst,
  input  stk_op_e       op_i,
  input  logic          ld_sp_i,
  input  logic          ld_ovf_i,
  input  logic          ld_unf_i,
  input  logic          ld_size_i,
  input  logic [AW-1:0] ld_data_i,
  output logic [AW-1:0] sp_o,
  output logic [AW-1:0] sp_dec_o,
  output logic [AW-1:0] sp_inc_o,
  output logic [AW-1:0] ovf_lim_o,
  output logic [AW-1:0] unf_lim_o,
  output sz_code_t      size_o
);

  localparam logic [AW-1:0] STEP  = AW'(2);
  localparam logic [AW-1:0] ALIGN = ~AW'(1);

  logic [AW-1:0] sp_q, ovf_q, unf_q;
  sz_code_t      size_q;

  assign sp_dec_o = sp_q - STEP;
  assign sp_inc_o = sp_q + STEP;

  always_ff @(posedge clk) begin
    if (rst) begin
      sp_q   <= RST_SP & ALIGN;
      ovf_q  <= RST_OVF;
      unf_q  <= RST_UNF;
      size_q <= SZ_BASE;
    end else begin
      if (ld_sp_i)              sp_q <= ld_data_i & ALIGN;
      else if (op_i == OP_PUSH) sp_q <= sp_dec_o;
      else if (op_i == OP_POP)  sp_q <= sp_inc_o;
      if (ld_ovf_i)  ovf_q  <= ld_data_i;
      if (ld_unf_i)  unf_q  <= ld_data_i;
      if (ld_size_i) size_q <= ld_data_i[SZ_CODE_W-1:0];
    end
  end

  assign sp_o      = sp_q;
  assign ovf_lim_o = ovf_q;
  assign unf_lim_o = unf_q;
  assign size_o    = size_q;

endmodule

// File: rtl/stk_addr_splice.sv
module stk_addr_splice
  import stkmap_pkg::*;
#(
  parameter int unsigned   AW        = 16,
  parameter int unsigned   BASE_LOG2 = 8,
  parameter logic [AW-1:0] TOP_LIMIT = 16'hFBFE
) (
  input  logic [AW-1:0] ptr_i,
  input  sz_code_t      size_i,
  output logic [AW-1:0] phys_o
);

  localparam logic [AW-1:0] ALIGN = ~AW'(1);

  logic [AW-1:0] mask_tbl [NUM_CODES];
  logic [AW-1:0] sel_mask;

  // One constant keep-mask per size code; bit 0 never comes from the pointer.
  for (genvar c = 0; c < NUM_CODES; c++) begin : g_code
    localparam int unsigned KEEP = keep_bits(sz_code_t'(c), BASE_LOG2, AW);
    for (genvar b = 0; b < AW; b++) begin : g_bit
      assign mask_tbl[c][b] = (b > 0) && (b < KEEP);
    end
  end

  assign sel_mask = mask_tbl[size_i];
  assign phys_o   = ((TOP_LIMIT & ~sel_mask) | (ptr_i & sel_mask)) & ALIGN;

endmodule

// File: rtl/stk_limit_flags.sv
module stk_limit_flags
  import stkmap_pkg::*;
#(
  parameter int unsigned AW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  stk_op_e       op_i,
  input  logic [AW-1:0] sp_dec_i,
  input  logic [AW-1:0] sp_inc_i,
  input  logic [AW-1:0] ovf_lim_i,
  input  logic [AW-1:0] unf_lim_i,
  input  logic          clr_ovf_i,
  input  logic          clr_unf_i,
  output logic          ovf_o,
  output logic          unf_o
);

  logic set_ovf, set_unf;
  logic ovf_q, unf_q;

  assign set_ovf = (op_i == OP_PUSH) && (sp_dec_i < ovf_lim_i);
  assign set_unf = (op_i == OP_POP)  && (sp_inc_i > unf_lim_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      ovf_q <= 1'b0;
      unf_q <= 1'b0;
    end else begin
      ovf_q <= set_ovf | (ovf_q & ~clr_ovf_i);
      unf_q <= set_unf | (unf_q & ~clr_unf_i);
    end
  end

  assign ovf_o = ovf_q;
  assign unf_o = unf_q;

endmodule

// File: rtl/stk_circ_mapper.sv
module stk_circ_mapper
  import stkmap_pkg::*;
#(
  parameter int unsigned   AW        = 16,
  parameter int unsigned   BASE_LOG2 = 8,
  parameter logic [AW-1:0] TOP_LIMIT = 16'hFBFE,
  parameter logic [AW-1:0] RST_SP    = 16'hFC00,
  parameter logic [AW-1:0] RST_OVF   = 16'hFA00,
  parameter logic [AW-1:0] RST_UNF   = 16'hFC00
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic          ld_sp_i,
  input  logic          ld_ovf_i,
  input  logic          ld_unf_i,
  input  logic          ld_size_i,
  input  logic [AW-1:0] ld_data_i,
  input  logic          clr_ovf_i,
  input  logic          clr_unf_i,
  output logic [AW-1:0] sp_o,
  output logic [AW-1:0] phys_addr_o,
  output logic          addr_vld_o,
  output logic          ovf_flag_o,
  output logic          unf_flag_o
);

  stk_op_e       op;
  logic [AW-1:0] sp_q, sp_dec, sp_inc, ovf_lim, unf_lim;
  logic [AW-1:0] addr_src, addr_phys;
  sz_code_t      size_q;
  logic [AW-1:0] addr_q;
  logic          vld_q;

  stk_op_decode u_dec (
    .push_i (push_i),
    .pop_i  (pop_i),
    .hold_i (ld_sp_i),
    .op_o   (op)
  );

  stk_ptr_regs #(
    .AW(AW), .RST_SP(RST_SP), .RST_OVF(RST_OVF), .RST_UNF(RST_UNF)
  ) u_regs (
    .clk       (clk),
    .rst       (rst),
    .op_i      (op),
    .ld_sp_i   (ld_sp_i),
    .ld_ovf_i  (ld_ovf_i),
    .ld_unf_i  (ld_unf_i),
    .ld_size_i (ld_size_i),
    .ld_data_i (ld_data_i),
    .sp_o      (sp_q),
    .sp_dec_o  (sp_dec),
    .sp_inc_o  (sp_inc),
    .ovf_lim_o (ovf_lim),
    .unf_lim_o (unf_lim),
    .size_o    (size_q)
  );

  // Push addresses the pre-decremented slot, pop the current one.
  assign addr_src = (op == OP_PUSH) ? sp_dec : sp_q;

  stk_addr_splice #(
    .AW(AW), .BASE_LOG2(BASE_LOG2), .TOP_LIMIT(TOP_LIMIT)
  ) u_splice (
    .ptr_i  (addr_src),
    .size_i (size_q),
    .phys_o (addr_phys)
  );

  stk_limit_flags #(.AW(AW)) u_flags (
    .clk       (clk),
    .rst       (rst),
    .op_i      (op),
    .sp_dec_i  (sp_dec),
    .sp_inc_i  (sp_inc),
    .ovf_lim_i (ovf_lim),
    .unf_lim_i (unf_lim),
    .clr_ovf_i (clr_ovf_i),
    .clr_unf_i (clr_unf_i),
    .ovf_o     (ovf_flag_o),
    .unf_o     (unf_flag_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      vld_q <= (op != OP_IDLE);
      if (op != OP_IDLE) addr_q <= addr_phys;
    end
  end

  assign sp_o        = sp_q;
  assign phys_addr_o = addr_q;
  assign addr_vld_o  = vld_q;

endmodule

// File: rtl/stk_circ_mapper_chk.sv
module stk_circ_mapper_chk #(
  parameter int unsigned   AW        = 16,
  parameter int unsigned   BASE_LOG2 = 8,
  parameter logic [AW-1:0] TOP_LIMIT = 16'hFBFE,
  parameter logic [AW-1:0] RST_SP    = 16'hFC00
) (
  input logic          clk,
  input logic          rst,
  input logic          push_i,
  input logic          pop_i,
  input logic          ld_sp_i,
  input logic [AW-1:0] ld_data_i,
  input logic          clr_ovf_i,
  input logic          clr_unf_i,
  input logic [2:0]    size_q,
  input logic [AW-1:0] sp_o,
  input logic [AW-1:0] phys_addr_o,
  input logic          addr_vld_o,
  input logic          ovf_flag_o,
  input logic          unf_flag_o
);

  localparam int unsigned   LOW_BASE = BASE_LOG2 + 1;
  localparam logic [AW-1:0] ALIGN    = ~AW'(1);
  localparam logic [AW-1:0] STEP     = AW'(2);

  logic do_push, do_pop;
  assign do_push = push_i && !pop_i && !ld_sp_i;
  assign do_pop  = pop_i && !push_i && !ld_sp_i;

  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (sp_o == (RST_SP & ALIGN)) && !addr_vld_o && !ovf_flag_o && !unf_flag_o);

  a_r2_push_step: assert property (@(posedge clk) disable iff (rst)
    do_push |=> (sp_o == $past(sp_o) - STEP) && addr_vld_o);

  a_r3_pop_step: assert property (@(posedge clk) disable iff (rst)
    do_pop |=> (sp_o == $past(sp_o) + STEP) && addr_vld_o);

  a_r4_base_window: assert property (@(posedge clk) disable iff (rst)
    (do_push && size_q == 3'd0) |=>
      (phys_addr_o[AW-1:LOW_BASE] == TOP_LIMIT[AW-1:LOW_BASE]));

  a_r6_flat_pass: assert property (@(posedge clk) disable iff (rst)
    (do_push && size_q == 3'd7) |=> (phys_addr_o == sp_o));

  a_r8_word_aligned: assert property (@(posedge clk) disable iff (rst)
    (phys_addr_o[0] == 1'b0) && (sp_o[0] == 1'b0));

  a_r9_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
    (ovf_flag_o && !clr_ovf_i) |=> ovf_flag_o);

  a_r10_unf_sticky: assert property (@(posedge clk) disable iff (rst)
    (unf_flag_o && !clr_unf_i) |=> unf_flag_o);

  a_r11_both_ignored: assert property (@(posedge clk) disable iff (rst)
    (push_i && pop_i && !ld_sp_i) |=> $stable(sp_o) && !addr_vld_o);

  a_r12_load_wins: assert property (@(posedge clk) disable iff (rst)
    ld_sp_i |=> (sp_o == ($past(ld_data_i) & ALIGN)) && !addr_vld_o);

endmodule

bind stk_circ_mapper stk_circ_mapper_chk #(
  .AW(AW), .BASE_LOG2(BASE_LOG2), .TOP_LIMIT(TOP_LIMIT), .RST_SP(RST_SP)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .push_i      (push_i),
  .pop_i       (pop_i),
  .ld_sp_i     (ld_sp_i),
  .ld_data_i   (ld_data_i),
  .clr_ovf_i   (clr_ovf_i),
  .clr_unf_i   (clr_unf_i),
  .size_q      (size_q),
  .sp_o        (sp_o),
  .phys_addr_o (phys_addr_o),
  .addr_vld_o  (addr_vld_o),
  .ovf_flag_o  (ovf_flag_o),
  .unf_flag_o  (unf_flag_o)
);

// File: tb/stk_circ_mapper_test.sv
`timescale 1ns/1ps
module stk_circ_mapper_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        push_i = 0, pop_i = 0, ld_sp_i = 0, ld_ovf_i = 0, ld_unf_i = 0, ld_size_i = 0;
  logic [15:0] ld_data_i = '0;
  logic        clr_ovf_i = 0, clr_unf_i = 0;
  logic [15:0] sp_o, phys_addr_o;
  logic        addr_vld_o, ovf_flag_o, unf_flag_o;

  always #2 clk = ~clk;

  stk_circ_mapper uut (
    .clk(clk), .rst(rst), .push_i(push_i), .pop_i(pop_i), .ld_sp_i(ld_sp_i),
    .ld_ovf_i(ld_ovf_i), .ld_unf_i(ld_unf_i), .ld_size_i(ld_size_i),
    .ld_data_i(ld_data_i), .clr_ovf_i(clr_ovf_i), .clr_unf_i(clr_unf_i),
    .sp_o(sp_o), .phys_addr_o(phys_addr_o), .addr_vld_o(addr_vld_o),
    .ovf_flag_o(ovf_flag_o), .unf_flag_o(unf_flag_o)
  );

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  // Scoreboard: expected {addr, sp, ovf, unf} per valid operation.
  logic [33:0] exp_q [$];
  string       tag_q [$];

  // Reference model state
  logic [15:0] m_sp = 16'hFC00, m_ovf_lim = 16'hFA00, m_unf_lim = 16'hFC00;
  logic [2:0]  m_size = 3'd0;
  logic        m_ovf = 0, m_unf = 0;

  function automatic logic [15:0] m_map(input logic [15:0] p, input logic [2:0] c);
    int k;
    logic [15:0] m;
    case (c)
      3'd1: k = 8;
      3'd2: k = 7;
      3'd3: k = 6;
      3'd4: k = 10;
      3'd7: k = 16;
      default: k = 9;
    endcase
    m = 16'((32'h1 << k) - 1) & 16'hFFFE;
    return ((16'hFBFE & ~m) | (p & m)) & 16'hFFFE;
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input bit pu, input bit po, input bit lsp, input bit lovf,
                      input bit lunf, input bit lsz, input logic [15:0] d,
                      input bit cov, input bit cun, input string tag);
    logic [15:0] nsp, addr;
    bit is_push, is_pop, s_ovf, s_unf;
    @(negedge clk);
    push_i = pu; pop_i = po; ld_sp_i = lsp; ld_ovf_i = lovf; ld_unf_i = lunf;
    ld_size_i = lsz; ld_data_i = d; clr_ovf_i = cov; clr_unf_i = cun;
    is_push = pu && !po && !lsp;
    is_pop  = po && !pu && !lsp;
    nsp = m_sp; addr = '0; s_ovf = 0; s_unf = 0;
    if (is_push) begin
      nsp = m_sp - 16'd2; addr = m_map(nsp, m_size); s_ovf = nsp < m_ovf_lim;
    end else if (is_pop) begin
      addr = m_map(m_sp, m_size); nsp = m_sp + 16'd2; s_unf = nsp > m_unf_lim;
    end
    if (lsp) nsp = d & 16'hFFFE;
    m_ovf = s_ovf | (m_ovf & ~cov);
    m_unf = s_unf | (m_unf & ~cun);
    m_sp = nsp;
    if (lovf) m_ovf_lim = d;
    if (lunf) m_unf_lim = d;
    if (lsz)  m_size = d[2:0];
    if (is_push || is_pop) begin
      exp_q.push_back({addr, m_sp, m_ovf, m_unf});
      tag_q.push_back(tag);
    end
  endtask

  task automatic t_idle();                step(0,0,0,0,0,0,16'h0,0,0,"R2"); endtask
  task automatic t_push(input string t);  step(1,0,0,0,0,0,16'h0,0,0,t); endtask
  task automatic t_pop(input string t);   step(0,1,0,0,0,0,16'h0,0,0,t); endtask
  task automatic t_ld_sp(input logic [15:0] v)  ; step(0,0,1,0,0,0,v,0,0,"R12"); endtask
  task automatic t_ld_size(input logic [2:0] v) ; step(0,0,0,0,0,1,{13'h0,v},0,0,"R12"); endtask
  task automatic t_ld_ovf(input logic [15:0] v) ; step(0,0,0,1,0,0,v,0,0,"R12"); endtask
  task automatic t_ld_unf(input logic [15:0] v) ; step(0,0,0,0,1,0,v,0,0,"R12"); endtask

  // Monitor: compare each valid result against the scoreboard head.
  always @(negedge clk) begin
    if (!rst && addr_vld_o) begin
      if (exp_q.size() == 0) begin
        n_checks++; n_fail++;
        $display("FAIL R2 unexpected valid actual=%h expected=none", phys_addr_o);
      end else begin
        logic [33:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check({t, " addr"}, phys_addr_o, e[33:18]);
        check({t, " sp"},   sp_o,        e[17:2]);
        check({t, " ovf (R9)"}, {15'h0, ovf_flag_o}, {15'h0, e[1]});
        check({t, " unf (R10)"}, {15'h0, unf_flag_o}, {15'h0, e[0]});
      end
    end
  end

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL R2 watchdog actual=running expected=finished");
      finish_run();
    end
  end

  initial begin
    logic [15:0] lfsr;
    logic [15:0] held;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 0;
    // R1: reset state
    check("R1 sp", sp_o, 16'hFC00);
    check("R1 vld", {15'h0, addr_vld_o}, 16'h0);
    check("R1 flags", {14'h0, ovf_flag_o, unf_flag_o}, 16'h0);
    t_push("R1");                              // reset size/bounds used
    t_idle();
    check("R1 first push addr", phys_addr_o, 16'hFBFE);

    // R4 / R7 literal mapping, R9 overflow
    t_ld_sp(16'hF804);
    t_push("R4"); t_idle(); check("R4 F802", phys_addr_o, 16'hFA02);
    t_push("R4"); t_idle(); check("R4 F800", phys_addr_o, 16'hFA00);
    t_push("R7"); t_idle(); check("R7 wrap top", phys_addr_o, 16'hFBFE);
    check("R7 sp", sp_o, 16'hF7FE);
    check("R9 ovf set", {15'h0, ovf_flag_o}, 16'h1);
    step(1,0,0,0,0,0,16'h0,1,0,"R9");          // set wins over clear
    t_idle(); check("R9 set wins", {15'h0, ovf_flag_o}, 16'h1);
    step(0,0,0,0,0,0,16'h0,1,0,"R9");
    t_idle(); check("R9 cleared", {15'h0, ovf_flag_o}, 16'h0);
    t_ld_ovf(16'h0000);

    // R3 pops, wrap from top to bottom
    t_pop("R3"); t_pop("R3"); t_pop("R7");
    t_idle(); check("R7 pop bottom", phys_addr_o, 16'hFA00);
    check("R3 sp", sp_o, 16'hF802);

    // R5 other sizes
    t_ld_size(3'd2); t_ld_sp(16'hF800);
    t_push("R5"); t_idle(); check("R5 64w", phys_addr_o, 16'hFBFE);
    for (int c = 1; c < 7; c++) begin
      t_ld_size(3'(c)); t_ld_sp(16'hF908);
      for (int i = 0; i < 12; i++) t_push(c >= 5 ? "R6" : "R5");
      for (int i = 0; i < 14; i++) t_pop(c >= 5 ? "R6" : "R5");
    end
    // R6 pass-through and reserved
    t_ld_size(3'd7); t_ld_sp(16'h1234);
    t_push("R6"); t_idle(); check("R6 flat", phys_addr_o, 16'h1232);
    t_ld_size(3'd5); t_ld_sp(16'hF7FE);
    t_push("R6"); t_idle(); check("R6 reserved", phys_addr_o, 16'hFBFC);

    // R11 simultaneous push/pop ignored
    held = sp_o;
    step(1,1,0,0,0,0,16'h0,0,0,"R11");
    t_idle();
    check("R11 sp", sp_o, held);
    check("R11 vld", {15'h0, addr_vld_o}, 16'h0);

    // R12 / R8 load wins, odd data aligned
    step(1,0,1,0,0,0,16'hF001,0,0,"R12");
    t_idle();
    check("R8 aligned load", sp_o, 16'hF000);
    check("R12 no valid", {15'h0, addr_vld_o}, 16'h0);

    // R10 underflow
    t_ld_size(3'd0); t_ld_sp(16'hFBFE);
    t_pop("R10"); t_idle(); check("R10 clear", {15'h0, unf_flag_o}, 16'h0);
    t_pop("R10"); t_idle(); check("R10 set", {15'h0, unf_flag_o}, 16'h1);
    t_push("R10"); t_idle(); check("R10 sticky", {15'h0, unf_flag_o}, 16'h1);
    step(0,0,0,0,0,0,16'h0,0,1,"R10");
    t_idle(); check("R10 cleared", {15'h0, unf_flag_o}, 16'h0);
    t_ld_unf(16'hF000);
    t_pop("R12"); t_idle(); check("R12 new bound", {15'h0, unf_flag_o}, 16'h1);

    // Mixed traffic through the scoreboard
    lfsr = 16'hACE1;
    for (int i = 0; i < 400; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (lfsr[3:0] == 4'h0)      t_ld_size(lfsr[6:4]);
      else if (lfsr[3:0] == 4'h1) step(0,0,0,0,0,0,16'h0,lfsr[7],lfsr[8],"R9");
      else if (lfsr[3:0] == 4'h2) step(1,1,0,0,0,0,16'h0,0,0,"R11");
      else if (lfsr[9])           t_push("R2");
      else                        t_pop("R3");
    end
    t_idle(); t_idle();
    check("R2 scoreboard drained", 16'(exp_q.size()), 16'h0);
    done = 1;
    finish_run();
  end

endmodule